// File: doc/BRIEF.md
# SPI Flash Command Transfer Engine

This block is a register-programmed SPI master. It sends one burst of up to 64 bytes on a single data line each time software starts it. Software loads the bytes into a buffer window of sixteen 32-bit words. It then programs the bit count, the clock polarity, the select polarity, whether select stays held afterwards, and the serial clock rate. A write to the command register starts the burst. The engine can sample the input line during the burst and write each received byte back over the byte it has just sent. When the burst ends it raises a done flag, which software polls and later clears.

Holding select between bursts lets a long flash command be split into several buffer loads. All of those loads then sit inside one select window. Only clock phase 0 is supported, with one data line in each direction.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the done flag (slave register 0x30, bit 4) reads 0. The busy bit (command register 0x00, bit 18) reads 0. Select is inactive, so `spi_cs` is 1 because the default polarity is active low. `spi_sclk` and `spi_mosi` are both 0.
- R2: The buffer occupies addresses 0x40 to 0x7c as sixteen words. Buffer byte k sits in the word at 0x40 + 4·(k/4), at bits [8·(k mod 4)+7 : 8·(k mod 4)]. A written word reads back unchanged. A bus write to the buffer while a burst is in progress is dropped.
- R3: Writing a 1 to bit 18 of the command register at 0x00 starts a burst. That bit reads 1 while the burst runs and 0 once it has ended.
- R4: Bits [25:17] of the length register at 0x20 hold the bit count minus one. A burst produces exactly that many plus one clock pulses, so the value 511 gives a full 64-byte burst.
- R5: When bit 27 of the mode register at 0x1c is 1, the bytes go out on `spi_mosi` starting with buffer byte 0, each byte most significant bit first. When that bit is 0, `spi_mosi` stays 0 for the whole burst.
- R6: When bit 0 of the mode register is 1, the input line is sampled on each leading clock edge. Each completed received byte then replaces the buffer byte at the same position. When bit 0 is 0 the buffer keeps its contents.
- R7: The done flag is set when a burst ends. Writing the slave register with bit 4 at 0 clears it. Writing bit 4 at 1 never sets it.
- R8: Bit 23 of the select register at 0x2c makes select active high when 1 and active low when 0. Select holds its level for the whole burst. When bit 30 of that register is 1, select stays active after the burst. When bit 30 is 0, select goes inactive when the burst ends.
- R9: When bit 7 of the mode register is 1, the clock idles high and the leading edge is falling. When it is 0, the clock idles low and the leading edge is rising. Input is sampled on the leading edge and output changes after the trailing edge.
- R10: When bits [5:0] of the clock register at 0x18 hold D, each clock half period lasts D+1 system clock cycles.
- R11: A start written while a burst is in progress is ignored. The running burst neither restarts nor lengthens.
- R12: Writing a 1 to bit 31 of the slave register aborts any burst at once. Busy reads 0, select goes inactive, the done flag reads 0, and no further clock edges appear.
- R13: Bit 17 of the control register at 0x08 reads back what was written. It has no effect on bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte address of the register or buffer word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip select, polarity programmable |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The checker enforces several rules on every cycle:
- the clock sits at its programmed idle level whenever no burst runs;
- select holds still during a burst;
- the bit counter never passes the latched length;
- every burst that ends without an abort leaves the done flag set and select released when the keep bit was clear;
- an abort always leaves the engine idle.

Some properties need a model of the far end of the wire, so only the bench scenarios can show them. These are the bit order on the data line, the number of clock pulses, the received bytes that land in the buffer, the measured half-period width, and that a second start or a buffer write during a burst has no effect.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;
  // Register byte offsets (decoded by software drivers)
  localparam logic [6:0] OFS_CMD   = 7'h00;
  localparam logic [6:0] OFS_CTRL  = 7'h08;
  localparam logic [6:0] OFS_CLK   = 7'h18;
  localparam logic [6:0] OFS_USER  = 7'h1c;
  localparam logic [6:0] OFS_USER1 = 7'h20;
  localparam logic [6:0] OFS_USER4 = 7'h2c;
  localparam logic [6:0] OFS_SLAVE = 7'h30;

  // Field positions
  localparam int unsigned B_START = 18;
  localparam int unsigned B_RDEN  = 17;
  localparam int unsigned B_DOUT  = 27;
  localparam int unsigned B_DIN   = 0;
  localparam int unsigned B_CPOL  = 7;
  localparam int unsigned B_CSPOL = 23;
  localparam int unsigned B_KEEP  = 30;
  localparam int unsigned B_DONE  = 4;
  localparam int unsigned B_MODE  = 30;
  localparam int unsigned B_SRST  = 31;
  localparam int unsigned B_LEN   = 17;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic dout_en;
    logic din_en;
    logic cpol;
    logic cs_pol;
    logic keep_cs;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_xfer_regs.sv
`timescale 1ns/1ps
module spi_xfer_regs
  import spi_xfer_pkg::*;
#(
  parameter int unsigned LEN_W = 9,
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [6:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             busy,
  input  logic             done_set,
  output logic [31:0]      reg_rdata,
  output xfer_cfg_t        cfg,
  output logic [LEN_W-1:0] len,
  output logic [DIV_W-1:0] div,
  output logic             start,
  output logic             srst,
  output logic             done
);
  logic we_cmd, we_ctrl, we_clk, we_user, we_user1, we_user4, we_slave;
  assign we_cmd   = bus_wr && (bus_addr == OFS_CMD);
  assign we_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign we_clk   = bus_wr && (bus_addr == OFS_CLK);
  assign we_user  = bus_wr && (bus_addr == OFS_USER);
  assign we_user1 = bus_wr && (bus_addr == OFS_USER1);
  assign we_user4 = bus_wr && (bus_addr == OFS_USER4);
  assign we_slave = bus_wr && (bus_addr == OFS_SLAVE);

  assign start = we_cmd && bus_wdata[B_START] && !busy;
  assign srst  = we_slave && bus_wdata[B_SRST];

  logic             rden_q, rden_d;
  logic             dout_q, dout_d, din_q, din_d, cpol_q, cpol_d;
  logic             cspol_q, cspol_d, keep_q, keep_d;
  logic             mode_q, mode_d, done_q, done_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    rden_d  = rden_q;
    dout_d  = dout_q;
    din_d   = din_q;
    cpol_d  = cpol_q;
    cspol_d = cspol_q;
    keep_d  = keep_q;
    mode_d  = mode_q;
    len_d   = len_q;
    div_d   = div_q;
    done_d  = done_q;
    if (we_ctrl) rden_d = bus_wdata[B_RDEN];
    if (we_clk)  div_d  = bus_wdata[DIV_W-1:0];
    if (we_user) begin
      dout_d = bus_wdata[B_DOUT];
      din_d  = bus_wdata[B_DIN];
      cpol_d = bus_wdata[B_CPOL];
    end
    if (we_user1) len_d = bus_wdata[B_LEN +: LEN_W];
    if (we_user4) begin
      cspol_d = bus_wdata[B_CSPOL];
      keep_d  = bus_wdata[B_KEEP];
    end
    if (we_slave) begin
      mode_d = bus_wdata[B_MODE];
      if (!bus_wdata[B_DONE]) done_d = 1'b0;
    end
    if (srst)     done_d = 1'b0;
    if (done_set) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rden_q  <= 1'b0;
      dout_q  <= 1'b0;
      din_q   <= 1'b0;
      cpol_q  <= 1'b0;
      cspol_q <= 1'b0;
      keep_q  <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      len_q   <= '0;
      div_q   <= '0;
    end else begin
      rden_q  <= rden_d;
      dout_q  <= dout_d;
      din_q   <= din_d;
      cpol_q  <= cpol_d;
      cspol_q <= cspol_d;
      keep_q  <= keep_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      len_q   <= len_d;
      div_q   <= div_d;
    end
  end

  assign cfg  = '{dout_en: dout_q, din_en: din_q, cpol: cpol_q,
                  cs_pol: cspol_q, keep_cs: keep_q};
  assign len  = len_q;
  assign div  = div_q;
  assign done = done_q;

  always_comb begin
    reg_rdata = '0;
    unique case (bus_addr)
      OFS_CMD:   reg_rdata[B_START] = busy;
      OFS_CTRL:  reg_rdata[B_RDEN]  = rden_q;
      OFS_CLK:   reg_rdata[DIV_W-1:0] = div_q;
      OFS_USER: begin
        reg_rdata[B_DOUT] = dout_q;
        reg_rdata[B_CPOL] = cpol_q;
        reg_rdata[B_DIN]  = din_q;
      end
      OFS_USER1: reg_rdata[B_LEN +: LEN_W] = len_q;
      OFS_USER4: begin
        reg_rdata[B_KEEP]  = keep_q;
        reg_rdata[B_CSPOL] = cspol_q;
      end
      OFS_SLAVE: begin
        reg_rdata[B_MODE] = mode_q;
        reg_rdata[B_DONE] = done_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/spi_xfer_buf.sv
`timescale 1ns/1ps
module spi_xfer_buf #(
  parameter int unsigned BUF_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [$clog2(BUF_BYTES/4)-1:0] bus_widx,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rword,
  input  logic                          wb_en,
  input  logic [$clog2(BUF_BYTES)-1:0]  wb_idx,
  input  logic [7:0]                    wb_byte,
  input  logic [$clog2(BUF_BYTES)-1:0]  tx_idx,
  output logic [7:0]                    tx_byte
);
  localparam int unsigned WORDS  = BUF_BYTES / 4;
  localparam int unsigned IDX_W  = $clog2(BUF_BYTES);
  localparam int unsigned WIDX_W = $clog2(WORDS);

  logic [31:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic        bus_hit, wb_hit;
    logic [31:0] word_d;
    assign bus_hit = bus_we && (bus_widx == WIDX_W'(w));
    assign wb_hit  = wb_en && (wb_idx[IDX_W-1:2] == WIDX_W'(w));

    always_comb begin
      word_d = mem_q[w];
      if (bus_hit)     word_d = bus_wdata;
      else if (wb_hit) word_d[{wb_idx[1:0], 3'b000} +: 8] = wb_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mem_q[w] <= '0;
      else if (bus_hit || wb_hit) mem_q[w] <= word_d;
    end
  end

  assign bus_rword = mem_q[bus_widx];
  assign tx_byte   = mem_q[tx_idx[IDX_W-1:2]][{tx_idx[1:0], 3'b000} +: 8];
endmodule

// File: rtl/spi_xfer_shift.sv
`timescale 1ns/1ps
module spi_xfer_shift
  import spi_xfer_pkg::*;
#(
  parameter int unsigned LEN_W = 9,
  parameter int unsigned DIV_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               start,
  input  xfer_cfg_t          cfg,
  input  logic [LEN_W-1:0]   len,
  input  logic [DIV_W-1:0]   div,
  input  logic [7:0]         tx_byte,
  input  logic               miso,
  output logic               busy,
  output logic               done_set,
  output logic [LEN_W-4:0]   byte_idx,
  output logic               wb_en,
  output logic [7:0]         wb_byte,
  output logic               sclk,
  output logic               cs_out,
  output logic               mosi,
  output logic [LEN_W-1:0]   mon_cnt,
  output logic [LEN_W-1:0]   mon_len
);
  xfer_state_e      st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic             ph_q, ph_d, cs_q, cs_d, dout_q, dout_d, din_q, din_d;
  logic [7:0]       rx_q, rx_d;
  logic             tick;

  assign tick = (dcnt_q >= div);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    dcnt_d   = dcnt_q;
    ph_d     = ph_q;
    cs_d     = cs_q;
    dout_d   = dout_q;
    din_d    = din_q;
    rx_d     = rx_q;
    wb_en    = 1'b0;
    done_set = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_RUN;
        cnt_d  = '0;
        len_d  = len;
        dcnt_d = '0;
        ph_d   = 1'b0;
        cs_d   = 1'b1;
        dout_d = cfg.dout_en;
        din_d  = cfg.din_en;
      end
      ST_RUN: begin
        if (tick) begin
          dcnt_d = '0;
          if (!ph_q) begin
            ph_d = 1'b1;                    // leading edge: sample
            rx_d = {rx_q[6:0], miso};
          end else begin
            ph_d = 1'b0;                    // trailing edge: advance
            if (cnt_q[2:0] == 3'd7) wb_en = din_q;
            if (cnt_q == len_q) st_d  = ST_FIN;
            else                cnt_d = cnt_q + 1'b1;
          end
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
      ST_FIN: begin
        st_d     = ST_IDLE;
        done_set = 1'b1;
        if (!cfg.keep_cs) cs_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
    if (srst) begin
      st_d     = ST_IDLE;
      cs_d     = 1'b0;
      ph_d     = 1'b0;
      dcnt_d   = '0;
      wb_en    = 1'b0;
      done_set = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      dcnt_q <= '0;
      ph_q   <= 1'b0;
      cs_q   <= 1'b0;
      dout_q <= 1'b0;
      din_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      dcnt_q <= dcnt_d;
      ph_q   <= ph_d;
      cs_q   <= cs_d;
      dout_q <= dout_d;
      din_q  <= din_d;
      rx_q   <= rx_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign byte_idx = cnt_q[LEN_W-1:3];
  assign wb_byte  = rx_q;
  assign sclk     = cfg.cpol ^ ((st_q == ST_RUN) && ph_q);
  assign cs_out   = cs_q ^ ~cfg.cs_pol;
  assign mosi     = (st_q == ST_RUN) && dout_q && tx_byte[~cnt_q[2:0]];
  assign mon_cnt  = cnt_q;
  assign mon_len  = len_q;
endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned DIV_W     = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_cs,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int unsigned IDX_W  = $clog2(BUF_BYTES);
  localparam int unsigned LEN_W  = IDX_W + 3;
  localparam int unsigned WIDX_W = $clog2(BUF_BYTES / 4);

  xfer_cfg_t        cfg;
  logic [LEN_W-1:0] len, mon_cnt, mon_len;
  logic [DIV_W-1:0] div;
  logic             start, srst, done, busy, done_set, wb_en;
  logic [31:0]      reg_rdata, buf_rword;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       tx_byte, wb_byte;
  logic             buf_sel;

  assign buf_sel = bus_addr[6];

  spi_xfer_regs #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .done_set(done_set),
    .reg_rdata(reg_rdata), .cfg(cfg), .len(len), .div(div),
    .start(start), .srst(srst), .done(done)
  );

  spi_xfer_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_wr && buf_sel && !busy),
    .bus_widx(bus_addr[WIDX_W+1:2]), .bus_wdata(bus_wdata),
    .bus_rword(buf_rword), .wb_en(wb_en), .wb_idx(byte_idx),
    .wb_byte(wb_byte), .tx_idx(byte_idx), .tx_byte(tx_byte)
  );

  spi_xfer_shift #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .srst(srst), .start(start), .cfg(cfg),
    .len(len), .div(div), .tx_byte(tx_byte), .miso(spi_miso),
    .busy(busy), .done_set(done_set), .byte_idx(byte_idx),
    .wb_en(wb_en), .wb_byte(wb_byte), .sclk(spi_sclk), .cs_out(spi_cs),
    .mosi(spi_mosi), .mon_cnt(mon_cnt), .mon_len(mon_len)
  );

  assign bus_rdata = buf_sel ? buf_rword : reg_rdata;
endmodule

// File: rtl/spi_xfer_chk.sv
`timescale 1ns/1ps
module spi_xfer_chk
  import spi_xfer_pkg::*;
#(
  parameter int unsigned LEN_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             srst,
  input logic             done,
  input logic             spi_sclk,
  input logic             spi_cs,
  input xfer_cfg_t        cfg,
  input logic [LEN_W-1:0] mon_cnt,
  input logic [LEN_W-1:0] mon_len
);
  // R9: clock rests at its programmed polarity between bursts
  a_r9_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == cfg.cpol));

  // R8: select does not move while a burst runs
  a_r8_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs));

  // R8: select released at the end unless keep was set
  a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(cfg.keep_cs)) |-> (spi_cs == !cfg.cs_pol));

  // R7: a completed burst leaves the done flag set
  a_r7_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(srst)) |-> done);

  // R4: bit counter never passes the latched length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mon_cnt <= mon_len));

  // R12: abort returns the engine to idle
  a_r12_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !done));
endmodule

bind spi_xfer_engine spi_xfer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .srst(srst), .done(done),
  .spi_sclk(spi_sclk), .spi_cs(spi_cs), .cfg(cfg),
  .mon_cnt(mon_cnt), .mon_len(mon_len)
);

// File: tb/spi_xfer_engine_tb.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb;
  localparam logic [6:0] A_CMD = 7'h00, A_CTRL = 7'h08, A_CLK = 7'h18,
                         A_USER = 7'h1c, A_USER1 = 7'h20, A_USER4 = 7'h2c,
                         A_SLAVE = 7'h30;

  typedef struct packed {
    logic [6:0] nbytes;
    logic       cpol;
    logic       dout;
    logic       din;
    logic       cspol;
    logic       keep;
    logic [5:0] div;
    logic [9:0] pulses;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{7'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 10'd8},
    '{7'd4,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd1, 10'd32},
    '{7'd7,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd2, 10'd56},
    '{7'd64, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 10'd512},
    '{7'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0, 10'd24},
    '{7'd2,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'd3, 10'd16}
  };

  logic        clk, rst_n, bus_wr, spi_miso;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sclk, spi_cs, spi_mosi;

  spi_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_cs(spi_cs), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // far-end device model
  logic [7:0] txp [64];
  logic [7:0] rsp [64];
  logic [7:0] got [64];
  bit  mdl_on = 0;
  logic mdl_idle = 0, mdl_act = 0;
  int  mdl_bit = 0, mdl_pulses = 0, cs_bad = 0;
  longint t_lead = 0, mdl_width = 0;

  always @(spi_sclk) begin
    if (mdl_on && rst_n) begin
      if (spi_sclk != mdl_idle) begin
        if (mdl_bit < 512) got[mdl_bit/8][7-(mdl_bit%8)] = spi_mosi;
        if (spi_cs !== mdl_act) cs_bad++;
        mdl_bit++;
        mdl_pulses++;
        t_lead = $time;
      end else begin
        mdl_width = $time - t_lead;
        if (mdl_bit < 512) spi_miso = rsp[mdl_bit/8][7-(mdl_bit%8)];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] d;
    int t;
    d = 0; t = 0;
    while (!d[4] && t < 20000) begin
      bus_read(A_SLAVE, d);
      t++;
    end
  endtask

  task automatic load_buffer(input int seed);
    for (int k = 0; k < 64; k++) begin
      txp[k] = 8'((seed * 7) + (k * 13) + 5);
      rsp[k] = 8'((seed * 29) ^ (k * 11) ^ 165);
    end
    for (int w = 0; w < 16; w++)
      bus_write(7'(64 + w * 4), {txp[4*w+3], txp[4*w+2], txp[4*w+1], txp[4*w]});
  endtask

  task automatic setup(input int n, input logic cpol, input logic dout, input logic din,
                       input logic cspol, input logic keep, input logic [5:0] div);
    bus_write(A_CLK, {26'd0, div});
    bus_write(A_USER, (32'(dout) << 27) | (32'(cpol) << 7) | 32'(din));
    bus_write(A_USER1, 32'(8 * n - 1) << 17);
    bus_write(A_USER4, (32'(keep) << 30) | (32'(cspol) << 23));
    bus_write(A_SLAVE, 32'd0);
    mdl_idle = cpol; mdl_act = cspol;
    mdl_bit = 0; mdl_pulses = 0; cs_bad = 0;
    for (int k = 0; k < 64; k++) got[k] = 8'h00;
    spi_miso = rsp[0][7];
    mdl_on = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int mism;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; spi_miso = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    bus_read(A_SLAVE, d); chk("R1 done", {31'd0, d[4]}, 0);
    bus_read(A_CMD, d);   chk("R1 busy", {31'd0, d[18]}, 0);
    chk("R1 cs", {31'd0, spi_cs}, 1);
    chk("R1 sclk", {31'd0, spi_sclk}, 0);
    chk("R1 mosi", {31'd0, spi_mosi}, 0);

    // R2 buffer map
    bus_write(7'h40, 32'h44332211);
    bus_write(7'h7c, 32'hcafef00d);
    bus_read(7'h40, d); chk("R2 word0", d, 32'h44332211);
    bus_read(7'h7c, d); chk("R2 word15", d, 32'hcafef00d);

    // R13 direct-read enable storage
    bus_write(A_CTRL, 32'h0002_0000);
    bus_read(A_CTRL, d); chk("R13 rden set", d, 32'h0002_0000);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      load_buffer(v + 1);
      setup(int'(VECS[v].nbytes), VECS[v].cpol, VECS[v].dout, VECS[v].din,
            VECS[v].cspol, VECS[v].keep, VECS[v].div);
      bus_write(A_CMD, 32'h0004_0000);
      wait_done();
      mdl_on = 0;
      bus_read(A_SLAVE, d); chk("R7 done set", {31'd0, d[4]}, 1);
      bus_read(A_CMD, d);   chk("R3 busy clear", {31'd0, d[18]}, 0);
      chk("R4 pulses", mdl_pulses, 32'(VECS[v].pulses));
      mism = 0;
      for (int k = 0; k < int'(VECS[v].nbytes); k++)
        if (got[k] !== (VECS[v].dout ? txp[k] : 8'h00)) mism++;
      chk("R5 bytes on line", mism, 0);
      mism = 0;
      for (int k = 0; k < 64; k++) begin
        bus_read(7'(64 + (k / 4) * 4), d);
        if (d[(k%4)*8 +: 8] !== ((k < int'(VECS[v].nbytes) && VECS[v].din) ? rsp[k] : txp[k]))
          mism++;
      end
      chk("R6 buffer after", mism, 0);
      chk("R8 cs during burst", cs_bad, 0);
      chk("R8 cs after", {31'd0, spi_cs},
          {31'd0, (VECS[v].keep ? VECS[v].cspol : ~VECS[v].cspol)});
      chk("R9 sclk idle", {31'd0, spi_sclk}, {31'd0, VECS[v].cpol});
      chk("R10 half period", 32'(mdl_width), (32'(VECS[v].div) + 1) * 10);
    end

    // R7 done clear and no set by writing one
    bus_write(A_SLAVE, 32'd0);
    bus_read(A_SLAVE, d); chk("R7 cleared", {31'd0, d[4]}, 0);
    bus_write(A_SLAVE, 32'h10);
    bus_read(A_SLAVE, d); chk("R7 write one", {31'd0, d[4]}, 0);

    // R11 start while busy ignored, R2 buffer write while busy dropped
    load_buffer(9);
    setup(2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd7);
    bus_write(A_CMD, 32'h0004_0000);
    repeat (30) @(negedge clk);
    bus_read(A_CMD, d); chk("R3 busy set", {31'd0, d[18]}, 1);
    bus_write(A_CMD, 32'h0004_0000);
    bus_write(7'h68, 32'hdeadbeef);
    wait_done();
    mdl_on = 0;
    chk("R11 pulses", mdl_pulses, 16);
    bus_read(7'h68, d);
    chk("R2 busy write dropped", d, {txp[43], txp[42], txp[41], txp[40]});

    // R13 enable bit has no effect on a burst
    chk("R13 burst ok", mdl_bit, 16);
    bus_write(A_CTRL, 32'd0);
    bus_read(A_CTRL, d); chk("R13 rden clear", d, 0);

    // R12 soft reset aborts
    load_buffer(12);
    setup(64, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd5);
    bus_write(A_CMD, 32'h0004_0000);
    repeat (100) @(negedge clk);
    bus_write(A_SLAVE, 32'h8000_0000);
    bus_read(A_CMD, d);   chk("R12 busy", {31'd0, d[18]}, 0);
    bus_read(A_SLAVE, d); chk("R12 done", {31'd0, d[4]}, 0);
    chk("R12 cs", {31'd0, spi_cs}, 1);
    mism = mdl_pulses;
    repeat (300) @(negedge clk);
    chk("R12 no edges", mdl_pulses, mism);
    chk("R12 sclk", {31'd0, spi_sclk}, 0);
    mdl_on = 0;

    finish_run();
  end
endmodule